// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This unit lets a group of hardware participants meet at a common point before any of them goes on. Each participant pulses its arrive line once when it reaches the barrier, then waits for its done line. Arrivals are counted by the unit. When the number of arrivals in the current episode reaches the configured group size, every participant in the group is released in the same cycle.

The barrier can be reused without a separate reset phase. Each participant slot holds a private sense bit that it inverts on every accepted arrival. A single shared release flag is set to the new sense when an episode completes. A participant is free when the flag matches its own sense. A participant that leaves early and re-enters therefore waits for the flag to flip again, and it cannot disturb the participants that are still leaving the previous episode. Arrivals that occur in the same cycle are summed in one step, so the unit needs no lock around the counter.

Top module: `sense_barrier`

## Requirements
- R1: A synchronous active-low reset drives every done_o and err_o bit to 0 and clears the counter, the release flag and all sense bits. An episode that was partly built before the reset leaves no trace afterwards.
- R2: Bit k of arrive_i, done_o and err_o belongs to participant k. Each accepted arrive pulse adds one to the arrival counter, and no done_o bit rises while the count is below total_i.
- R3: On the clock edge where the arrivals bring the count to total_i, the counter returns to 0 and the release flag takes the new sense of the arrivers. From the next cycle, done_o is high for every participant that arrived in that episode.
- R4: Arrive pulses that occur in the same cycle are all counted in that cycle. If they fill the group, the group is released one cycle later.
- R5: After a release, done_o[k] stays high until participant k pulses arrive again. It then falls in the next cycle, unless that arrival itself completes the next episode.
- R6: An arrive pulse from a participant that has arrived and is not yet released is ignored and does not change the count. In the following cycle, and only in that cycle, err_o[k] is 1.
- R7: Release is decided by comparing the shared flag with each participant's own sense bit. A participant that re-enters early leaves the done_o of the others unchanged. A done_o bit rises only in a cycle where the release flag has just changed.
- R8: total_i selects a group size from 1 to N_PART, and that number of arrivals completes an episode. A participant that has never arrived since reset keeps done_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_i | input | N_PART | One-cycle arrive pulse per participant |
| total_i | input | CNT_W | Number of arrivals that complete an episode |
| done_o | output | N_PART | Participant released and may leave |
| err_o | output | N_PART | One-cycle flag for an arrive pulse that was ignored |

## Verification
The assertions assume that total_i lies between 1 and N_PART and does not change while an episode is open. The stimulus changes the group size only while reset is held. The assertions also assume that the arrivals accepted in one episode never exceed total_i, so the counter never jumps past the limit. The stimulus keeps to this by having each participant arrive at most once per episode. Repeated pulses are sent only while a participant is waiting, and those pulses are ignored by design.

// File: rtl/barrier_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the barrier participant slots.
// Assumes nothing beyond its callers passing single-bit state.
package barrier_pkg;

    // Observable condition of one participant slot.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,   // never arrived since reset
        SLOT_WAIT = 2'd1,   // arrived, release flag not yet equal to sense
        SLOT_FREE = 2'd2    // arrived and released
    } slot_state_e;

    // Classify a slot from its pending bit, its sense and the release flag.
    function automatic slot_state_e slot_decode(input logic pend,
                                                input logic sense,
                                                input logic rel);
        slot_state_e st;
        if (!pend) begin
            st = SLOT_IDLE;
        end else if (sense == rel) begin
            st = SLOT_FREE;
        end else begin
            st = SLOT_WAIT;
        end
        return st;
    endfunction

endpackage

// File: rtl/barrier_slot.sv
`timescale 1ns/1ps
// Module: barrier_slot
// Holds one participant's private sense bit and pending flag. It accepts an
// arrive pulse unless the participant is already waiting, and flags an
// ignored pulse for one cycle.
// Assumes: rel_i is the shared release flag, registered in the same clock.
module barrier_slot
    import barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic rel_i,
    output logic accept_o,
    output logic done_o,
    output logic err_o
);

    logic        pend_q;
    logic        sense_q;
    logic        err_q;
    slot_state_e st;

    // Decode the slot condition and gate the arrive pulse.
    always_comb begin
        st       = slot_decode(pend_q, sense_q, rel_i);
        accept_o = arrive_i && (st != SLOT_WAIT);
        done_o   = (st == SLOT_FREE);
    end

    // Flip the sense on accepted arrivals and record ignored ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            sense_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= arrive_i && (st == SLOT_WAIT);
            if (accept_o) begin
                pend_q  <= 1'b1;
                sense_q <= ~sense_q;
            end
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/barrier_tally.sv
`timescale 1ns/1ps
// Module: barrier_tally
// Sums all accepted arrivals of a cycle into the episode counter. When the
// sum reaches the configured total, it clears the counter and inverts the
// release flag. The new flag equals the new sense of every arriver.
// Assumes: total_i is between 1 and N_PART and is stable during an episode.
module barrier_tally #(
    parameter int N_PART = 4,
    parameter int CNT_W  = $clog2(N_PART + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] accept_i,
    input  logic [CNT_W-1:0]  total_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              rel_o
);

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             rel_q;
    logic [SUM_W-1:0] pop;
    logic [SUM_W-1:0] sum;
    logic             complete;

    // Count the accepted arrivals and decide whether the episode completes.
    always_comb begin
        pop = '0;
        for (int i = 0; i < N_PART; i++) begin
            pop = pop + SUM_W'(accept_i[i]);
        end
        sum      = {1'b0, cnt_q} + pop;
        complete = (pop != '0) && (sum >= {1'b0, total_i});
    end

    // Advance the counter, or clear it and flip the flag on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (complete) begin
            cnt_q <= '0;
            rel_q <= ~rel_q;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;
    assign rel_o = rel_q;

endmodule

// File: rtl/sense_barrier.sv
`timescale 1ns/1ps
// Module: sense_barrier (top)
// Sense-reversing barrier for N_PART participants. One slot per participant
// plus a shared tally holding the arrival counter and the release flag.
// Assumes: total_i is between 1 and N_PART, is changed only under reset, and
// each participant arrives at most once per episode.
module sense_barrier #(
    parameter int N_PART = 4,
    parameter int CNT_W  = $clog2(N_PART + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] arrive_i,
    input  logic [CNT_W-1:0]  total_i,
    output logic [N_PART-1:0] done_o,
    output logic [N_PART-1:0] err_o
);

    logic [N_PART-1:0] accept;
    logic [CNT_W-1:0]  arr_cnt;
    logic              rel_flag;

    // One slot per participant.
    for (genvar k = 0; k < N_PART; k++) begin : g_slot
        barrier_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arrive_i (arrive_i[k]),
            .rel_i    (rel_flag),
            .accept_o (accept[k]),
            .done_o   (done_o[k]),
            .err_o    (err_o[k])
        );
    end

    // Shared arrival counter and release flag.
    barrier_tally #(
        .N_PART (N_PART),
        .CNT_W  (CNT_W)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .total_i  (total_i),
        .cnt_o    (arr_cnt),
        .rel_o    (rel_flag)
    );

endmodule

// File: rtl/sense_barrier_chk.sv
`timescale 1ns/1ps
// Module: sense_barrier_chk
// Property checker for sense_barrier, attached by bind below.
// Assumes the input limits listed in the brief.
module sense_barrier_chk #(
    parameter int N_PART = 4,
    parameter int CNT_W  = $clog2(N_PART + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PART-1:0] arrive_i,
    input logic [CNT_W-1:0]  total_i,
    input logic [N_PART-1:0] done_o,
    input logic [N_PART-1:0] err_o,
    input logic [N_PART-1:0] accept,
    input logic [CNT_W-1:0]  arr_cnt,
    input logic              rel_flag
);

    AST_COUNT_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_cnt < total_i); // R2

    AST_FLAG_FLIP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rel_flag) |-> (arr_cnt == '0)); // R3

    for (genvar k = 0; k < N_PART; k++) begin : g_part
        AST_DONE_DROPS_ON_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (arrive_i[k] && done_o[k]) |=> (!done_o[k] || !$stable(rel_flag))); // R5

        AST_IGNORED_ARRIVE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
            (arrive_i[k] && !accept[k]) |=> err_o[k]); // R6

        AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[k] |-> $past(arrive_i[k] && !accept[k])); // R6

        AST_DONE_RISES_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_o[k]) |-> !$stable(rel_flag)); // R7
    end

endmodule

bind sense_barrier sense_barrier_chk #(
    .N_PART (N_PART),
    .CNT_W  (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arrive_i (arrive_i),
    .total_i  (total_i),
    .done_o   (done_o),
    .err_o    (err_o),
    .accept   (accept),
    .arr_cnt  (arr_cnt),
    .rel_flag (rel_flag)
);

// File: tb/sense_barrier_tb_top.sv
`timescale 1ns/1ps
// Bench for sense_barrier: a vector table and then directed corner cases.
module sense_barrier_tb_top;

    localparam int NP = 4;
    localparam int CW = $clog2(NP + 1);
    localparam int NVEC = 12;

    // Each entry: {arrive, expected done, expected err}, nibbles with bit k = participant k.
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0000_0000_0000,
        12'b0001_0000_0000,
        12'b0001_0000_0001,
        12'b0110_0000_0000,
        12'b1000_1111_0000,
        12'b0001_1110_0000,
        12'b0000_1110_0000,
        12'b0001_1110_0001,
        12'b1110_1111_0000,
        12'b1111_1111_0000,
        12'b0011_1100_0000,
        12'b1100_1111_0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive = '0;
    logic [CW-1:0] total = CW'(NP);
    logic [NP-1:0] done;
    logic [NP-1:0] err;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    sense_barrier #(.N_PART(NP)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive),
        .total_i  (total),
        .done_o   (done),
        .err_o    (err)
    );

    function automatic string vec_req(input int idx);
        case (idx)
            0:       return "R1";
            1, 3:    return "R2";
            4, 8:    return "R3";
            9:       return "R4";
            5, 10:   return "R5";
            2, 7:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic expect_out(input string req, input logic [NP-1:0] d_exp,
                              input logic [NP-1:0] e_exp);
        checks++;
        if (done !== d_exp) begin
            errors++;
            $display("FAIL %s done_o actual=%b expected=%b", req, done, d_exp);
        end
        checks++;
        if (err !== e_exp) begin
            errors++;
            $display("FAIL %s err_o actual=%b expected=%b", req, err, e_exp);
        end
    endtask

    // Apply arrive for one clock edge; return at the following falling edge.
    task automatic tick(input logic [NP-1:0] a);
        arrive = a;
        @(negedge clk);
        arrive = '0;
    endtask

    task automatic do_reset(input int grp);
        rst_n = 1'b0;
        arrive = '0;
        total = CW'(grp);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(NP);
        expect_out("R1", 4'b0000, 4'b0000);

        for (int i = 0; i < NVEC; i++) begin
            tick(VEC[i][11:8]);
            expect_out(vec_req(i), VEC[i][7:4], VEC[i][3:0]);
        end

        // R1: an open episode is forgotten across reset.
        do_reset(NP);
        tick(4'b0001);
        do_reset(NP);
        expect_out("R1", 4'b0000, 4'b0000);
        tick(4'b1110);
        expect_out("R1", 4'b0000, 4'b0000);
        tick(4'b0001);
        expect_out("R3", 4'b1111, 4'b0000);

        // R6: err lasts one cycle, and an ignored pulse is not counted.
        tick(4'b0001);
        expect_out("R5", 4'b1110, 4'b0000);
        tick(4'b0001);
        expect_out("R6", 4'b1110, 4'b0001);
        tick(4'b0000);
        expect_out("R6", 4'b1110, 4'b0000);
        tick(4'b0110);
        expect_out("R6", 4'b1000, 4'b0000);
        tick(4'b1000);
        expect_out("R6", 4'b1111, 4'b0000);

        // R8: group of two; idle participants stay low.
        do_reset(2);
        tick(4'b0001);
        expect_out("R8", 4'b0000, 4'b0000);
        tick(4'b0010);
        expect_out("R8", 4'b0011, 4'b0000);
        tick(4'b0011);
        expect_out("R4", 4'b0011, 4'b0000);

        // R8: group of one releases at once on every arrival.
        do_reset(1);
        tick(4'b0100);
        expect_out("R8", 4'b0100, 4'b0000);
        tick(4'b0100);
        expect_out("R5", 4'b0100, 4'b0000);
        tick(4'b0000);
        expect_out("R8", 4'b0100, 4'b0000);

        // R2: group of three, one arrival per cycle.
        do_reset(3);
        tick(4'b1000);
        expect_out("R2", 4'b0000, 4'b0000);
        tick(4'b0100);
        expect_out("R2", 4'b0000, 4'b0000);
        tick(4'b0010);
        expect_out("R3", 4'b1110, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule